// File: doc/BRIEF.md
# Received Packet Length and Address Filter

This block sits behind sync-word detection in a packet receiver. It takes the received bytes of one packet as a stream, with a start marker on the first byte, and decides before anything goes downstream whether the packet is wanted. The length can be fixed by configuration. It can also be read from the first byte of the packet and limited by the configured maximum. One address byte can be matched against the device address under one of four filtering modes, two of which also accept broadcast values.

An accepted packet is passed on byte for byte. It can be followed by two receive-status bytes made from the signal strength, the link quality and the checksum result supplied beside the stream. A rejected packet produces one drop pulse and no output bytes. To make this possible, the block always holds one byte back. Every forwarded byte leaves the block only when the next byte of the packet arrives, or, for the final byte, in the cycle after it. Upstream must leave at least three idle cycles between packets, which any sync search provides.

Top module: `pkt_len_addr_filter`

## Requirements
- R1: After reset, `out_valid`, `out_last` and `drop` are low and stay low until a packet is presented.
- R2: With `cfg_var_len` low, exactly `cfg_max_len` bytes, counted from the byte with `in_sop`, are forwarded unchanged and in order. Later input bytes without `in_sop` are ignored.
- R3: With `cfg_var_len` high, the first byte is a length L giving the number of bytes after it. The L+1 bytes, the length byte included, are forwarded unchanged and in order.
- R4: In variable mode a packet with L equal to 0 or L greater than `cfg_max_len` is rejected. In fixed mode, `cfg_max_len` equal to 0 rejects every packet.
- R5: `cfg_addr_mode` = 0 accepts any address byte.
- R6: `cfg_addr_mode` = 1 accepts only an address byte equal to `cfg_dev_addr`.
- R7: `cfg_addr_mode` = 2 accepts an address byte equal to `cfg_dev_addr` or to 0x00.
- R8: `cfg_addr_mode` = 3 accepts an address byte equal to `cfg_dev_addr`, to 0x00 or to 0xFF.
- R9: The address byte is the byte with `in_sop` in fixed mode and the byte right after it in variable mode.
- R10: A rejected packet gives exactly one `drop` pulse, in the cycle after the deciding byte. No byte of that packet is output.
- R11: With `cfg_append` high, two bytes follow the payload. The first is `st_rssi`. The second holds `st_crc_ok` in bit 7 and `st_lqi` in bits 6:0. Both are taken in the cycle the final payload byte is presented.
- R12: An accepted packet carries exactly one `out_last`. It sits on the final payload byte when appending is off, and on the second status byte when it is on.
- R13: Bytes with `in_valid` but no `in_sop` outside a packet are ignored. An `in_sop` inside an unfinished packet starts a new packet and discards the byte held back from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_var_len | input | 1 | 1: length taken from the first byte; 0: fixed length |
| cfg_max_len | input | 8 | Fixed length, or the largest length allowed in variable mode |
| cfg_addr_mode | input | 2 | Address filter mode, 0 to 3 |
| cfg_dev_addr | input | 8 | Device address |
| cfg_append | input | 1 | Append two status bytes |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_data | input | 8 | Input byte |
| st_rssi | input | 8 | Signal strength value |
| st_lqi | input | 7 | Link quality value |
| st_crc_ok | input | 1 | Checksum result |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a forwarded packet |
| drop | output | 1 | One-cycle pulse for a rejected packet |

## Verification
The address filter is swept over every mode in both length modes, with appending on and off. Each sweep uses address bytes equal to the device address, 0x00, 0xFF and an unrelated value, so the four modes are told apart by which of the four values each one admits. A length sweep runs from 0 to beyond the maximum in variable mode and from 0 upward in fixed mode, which pins down the limit, the zero case and the trailing-byte cut-off. Extra patterns place the device address in the wrong position for each length mode, send stray bytes without a start marker, and restart a packet after its first byte, so that the address position and the held-back byte are each observed on their own.

// File: rtl/pkt_filt_pkg.sv
package pkt_filt_pkg;

  parameter int BYTE_W = 8;
  localparam int LQI_W = BYTE_W - 1;

  typedef enum logic [1:0] {
    ADR_NONE  = 2'd0,
    ADR_EXACT = 2'd1,
    ADR_BC0   = 2'd2,
    ADR_BC0FF = 2'd3
  } adr_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_BODY,
    S_FLUSH,
    S_STAT1,
    S_STAT2
  } rx_state_e;

  // address filter decision for one candidate byte
  function automatic logic addr_pass(input logic [1:0] mode,
                                     input logic [BYTE_W-1:0] b,
                                     input logic [BYTE_W-1:0] dev);
    logic hit, zero, ones;
    hit  = (b == dev);
    zero = (b == '0);
    ones = (b == '1);
    case (adr_mode_e'(mode))
      ADR_NONE:  return 1'b1;
      ADR_EXACT: return hit;
      ADR_BC0:   return hit | zero;
      default:   return hit | zero | ones;
    endcase
  endfunction

  // variable length field check against the configured ceiling
  function automatic logic len_pass(input logic [BYTE_W-1:0] len,
                                    input logic [BYTE_W-1:0] ceiling);
    return (len != '0) && (len <= ceiling);
  endfunction

  // second appended byte: checksum flag on top, quality below
  function automatic logic [BYTE_W-1:0] stat_pack(input logic crc_ok,
                                                  input logic [LQI_W-1:0] lqi);
    return {crc_ok, lqi};
  endfunction

endpackage

// File: rtl/pkt_hdr_judge.sv
module pkt_hdr_judge
  import pkt_filt_pkg::*;
(
  input  logic              var_len,
  input  logic [BYTE_W-1:0] max_len,
  input  logic [1:0]        addr_mode,
  input  logic [BYTE_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              len_fail,
  output logic              adr_fail
);

  assign adr_fail = !addr_pass(addr_mode, byte_in, dev_addr);
  assign len_fail = var_len ? !len_pass(byte_in, max_len) : (max_len == '0);

  always_comb begin
    // R5
    if (addr_mode == 2'd0) none_mode_chk: assert (!adr_fail);
    // R8
    if (addr_mode == 2'd3 && byte_in == '1) bc_ff_chk: assert (!adr_fail);
  end

endmodule

// File: rtl/pkt_remain_ctr.sv
module pkt_remain_ctr
  import pkt_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              dec,
  output logic              at_final
);

  logic [BYTE_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  // one byte still to come: the next one ends the payload
  assign at_final = (cnt_q == {{(BYTE_W-1){1'b0}}, 1'b1});

endmodule

// File: rtl/pkt_status_unit.sv
module pkt_status_unit
  import pkt_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [BYTE_W-1:0] rssi,
  input  logic [LQI_W-1:0]  lqi,
  input  logic              crc_ok,
  input  logic              sel_second,
  output logic [BYTE_W-1:0] byte_out
);

  logic [BYTE_W-1:0] rssi_q;
  logic [BYTE_W-1:0] qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rssi_q <= '0;
      qual_q <= '0;
    end else if (cap) begin
      rssi_q <= rssi;
      qual_q <= stat_pack(crc_ok, lqi);
    end
  end

  assign byte_out = sel_second ? qual_q : rssi_q;

endmodule

// File: rtl/pkt_len_addr_filter.sv
module pkt_len_addr_filter
  import pkt_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_var_len,
  input  logic [BYTE_W-1:0] cfg_max_len,
  input  logic [1:0]        cfg_addr_mode,
  input  logic [BYTE_W-1:0] cfg_dev_addr,
  input  logic              cfg_append,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [BYTE_W-1:0] st_rssi,
  input  logic [LQI_W-1:0]  st_lqi,
  input  logic              st_crc_ok,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              drop
);

  rx_state_e         st_q, st_d;
  logic [BYTE_W-1:0] pend_q;
  logic              len_fail, adr_fail, ctr_final;
  logic [BYTE_W-1:0] stat_byte;

  // named events
  logic sop_evt, adr_evt, body_evt;
  logic len_reject, adr_reject, reject;
  logic first_take, push_evt, final_evt;
  logic need_addr;
  logic [BYTE_W-1:0] ctr_load_val;

  pkt_hdr_judge u_judge (
    .var_len   (cfg_var_len),
    .max_len   (cfg_max_len),
    .addr_mode (cfg_addr_mode),
    .dev_addr  (cfg_dev_addr),
    .byte_in   (in_data),
    .len_fail  (len_fail),
    .adr_fail  (adr_fail)
  );

  assign sop_evt   = in_valid && in_sop;
  assign adr_evt   = in_valid && !in_sop && (st_q == S_ADDR);
  assign body_evt  = in_valid && !in_sop && (st_q == S_BODY);
  assign need_addr = cfg_var_len && (cfg_addr_mode != 2'd0);

  assign len_reject = sop_evt && len_fail;
  assign adr_reject = (sop_evt && !len_fail && !cfg_var_len && adr_fail)
                    || (adr_evt && adr_fail);
  assign reject     = len_reject || adr_reject;

  assign first_take = sop_evt && !reject;
  assign push_evt   = body_evt || (adr_evt && !adr_fail);
  assign final_evt  = (push_evt && ctr_final)
                    || (first_take && !cfg_var_len
                        && cfg_max_len == {{(BYTE_W-1){1'b0}}, 1'b1});

  assign ctr_load_val = cfg_var_len ? in_data : (cfg_max_len - 1'b1);

  pkt_remain_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (first_take),
    .load_val (ctr_load_val),
    .dec      (push_evt),
    .at_final (ctr_final)
  );

  pkt_status_unit u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (final_evt),
    .rssi       (st_rssi),
    .lqi        (st_lqi),
    .crc_ok     (st_crc_ok),
    .sel_second (st_q == S_STAT2),
    .byte_out   (stat_byte)
  );

  always_comb begin
    st_d = st_q;
    if (sop_evt) begin
      if (reject)         st_d = S_IDLE;
      else if (final_evt) st_d = S_FLUSH;
      else if (need_addr) st_d = S_ADDR;
      else                st_d = S_BODY;
    end else if (push_evt) begin
      st_d = final_evt ? S_FLUSH : S_BODY;
    end else if (adr_reject) begin
      st_d = S_IDLE;
    end else begin
      case (st_q)
        S_FLUSH: st_d = cfg_append ? S_STAT1 : S_IDLE;
        S_STAT1: st_d = S_STAT2;
        S_STAT2: st_d = S_IDLE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      pend_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      drop      <= 1'b0;
    end else begin
      st_q      <= st_d;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      drop      <= reject;
      if (first_take || push_evt) pend_q <= in_data;
      if (push_evt) begin
        out_valid <= 1'b1;
        out_data  <= pend_q;
      end else if (!sop_evt) begin
        case (st_q)
          S_FLUSH: begin
            out_valid <= 1'b1;
            out_data  <= pend_q;
            out_last  <= !cfg_append;
          end
          S_STAT1: begin
            out_valid <= 1'b1;
            out_data  <= stat_byte;
          end
          S_STAT2: begin
            out_valid <= 1'b1;
            out_data  <= stat_byte;
            out_last  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> !out_valid);
  // R4
  len_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_reject |=> !out_valid);
  // R9
  adr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_ADDR) |-> !out_valid);
  // R12
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R12
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R11
  stat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_STAT2) |-> (out_valid && !out_last));

endmodule

// File: tb/pkt_len_addr_filter_test.sv
module pkt_len_addr_filter_test;
  localparam int CLK_NS = 10;
  localparam logic [7:0] DEV = 8'h02;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_var_len = 1'b0;
  logic [7:0] cfg_max_len = 8'd3;
  logic [1:0] cfg_addr_mode = 2'd0;
  logic [7:0] cfg_dev_addr = DEV;
  logic cfg_append = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [7:0] st_rssi = 8'h00;
  logic [6:0] st_lqi = 7'h00;
  logic st_crc_ok = 1'b0;
  logic out_valid, out_last, drop;
  logic [7:0] out_data;

  int checks = 0, errors = 0;
  int cap_n = 0, drop_n = 0, pkt_no = 0;
  logic [7:0] cap_d [0:31];
  logic       cap_l [0:31];
  logic [7:0] pk [0:15];

  always #(CLK_NS/2) clk = ~clk;

  pkt_len_addr_filter uut (.*);

  always @(negedge clk) if (rst_n) begin
    if (out_valid) begin
      if (cap_n < 32) begin cap_d[cap_n] = out_data; cap_l[cap_n] = out_last; end
      cap_n++;
    end
    if (drop) drop_n++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 16; i++) pk[i] = seed + 8'(i * 7) + 8'h31;
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_data = pk[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic run_pkt(input bit v, input logic [1:0] m, input bit app,
                         input logic [7:0] mx, input int nsend, input string req);
    int nf, ai, ne;
    bit lenok, addrok, ok;
    logic [7:0] a, eb;
    pkt_no++;
    cfg_var_len = v; cfg_addr_mode = m; cfg_append = app; cfg_max_len = mx;
    st_rssi = 8'h80 + 8'(pkt_no); st_lqi = 7'(pkt_no * 3); st_crc_ok = pkt_no[0];
    cap_n = 0; drop_n = 0;
    send(nsend);
    if (v) begin lenok = (pk[0] != 0) && (pk[0] <= mx); nf = int'(pk[0]) + 1; ai = 1; end
    else begin lenok = (mx != 0); nf = int'(mx); ai = 0; end
    a = pk[ai];
    addrok = (m == 0) || (a == DEV) || (m >= 2 && a == 8'h00) || (m == 3 && a == 8'hFF);
    ok = lenok && addrok;
    ne = ok ? nf + (app ? 2 : 0) : 0;
    chk(drop_n == (ok ? 0 : 1), {req, " R10"}, "drop count", drop_n, ok ? 0 : 1);
    chk(cap_n == ne, req, "byte count", cap_n, ne);
    if (cap_n == ne)
      for (int j = 0; j < ne; j++) begin
        if (j < nf) eb = pk[j];
        else if (j == nf) eb = st_rssi;
        else eb = {st_crc_ok, st_lqi};
        chk(cap_d[j] == eb, (j < nf) ? req : "R11", "byte", cap_d[j], eb);
        chk(cap_l[j] == (j == ne - 1), "R12", "last flag", cap_l[j], j == ne - 1);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string rq;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid && !out_last && !drop, "R1", "outputs in reset",
        {out_valid, out_last, drop}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_last && !drop, "R1", "outputs after reset",
        {out_valid, out_last, drop}, 0);

    // address modes x address values x length modes x append
    for (int v = 0; v < 2; v++)
      for (int m = 0; m < 4; m++)
        for (int k = 0; k < 4; k++)
          for (int ap = 0; ap < 2; ap++) begin
            fill(8'(m * 16 + k));
            if (v) pk[0] = 8'd3;
            pk[v] = (k == 0) ? DEV : (k == 1) ? 8'h00 : (k == 2) ? 8'hFF : 8'h33;
            rq = (m == 0) ? "R5" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R8";
            run_pkt(v[0], 2'(m), ap[0], v ? 8'd6 : 8'd3, v ? 5 : 4, rq);
          end

    // variable length sweep, R3 and R4
    for (int l = 0; l < 9; l++) begin
      fill(8'(l));
      pk[0] = 8'(l);
      run_pkt(1'b1, 2'd0, l[0], 8'd6, (l <= 6) ? l + 2 : 2,
              (l == 0 || l > 6) ? "R4" : "R3");
    end

    // fixed length sweep, R2 and R4
    for (int n = 0; n < 6; n++) begin
      fill(8'(n + 40));
      pk[0] = DEV;
      run_pkt(1'b0, 2'd1, n[0], 8'(n), n + 2, (n == 0) ? "R4" : "R2");
    end

    // R9 device address in the wrong place
    fill(8'h70); pk[0] = 8'h33; pk[1] = DEV;
    run_pkt(1'b0, 2'd1, 1'b0, 8'd3, 4, "R9");
    fill(8'h71); pk[0] = DEV; pk[1] = 8'h33;
    run_pkt(1'b1, 2'd1, 1'b0, 8'd6, 4, "R9");

    // R13 stray bytes outside a packet
    cap_n = 0; drop_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_data = DEV;
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(cap_n == 0 && drop_n == 0, "R13", "stray output", cap_n + drop_n, 0);

    // R13 restart after one byte of a packet
    @(negedge clk); in_valid = 1'b1; in_sop = 1'b1; in_data = 8'd4;
    cfg_var_len = 1'b1; cfg_addr_mode = 2'd0; cfg_max_len = 8'd6;
    fill(8'h90); pk[0] = 8'd2;
    run_pkt(1'b1, 2'd0, 1'b1, 8'd6, 3, "R13");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule